// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block times the programmed-I/O read and write strobes for four IDE drives spread over two channels. When the host raises a request for a drive, the block runs three phases. It first holds an address-setup phase with the strobe low. It then asserts the read or write strobe for the active phase, and after that releases the strobe for the recovery phase. Once recovery ends, it returns a one-cycle acknowledge.

The timing for each access comes from a small bank of configuration registers. Each register set has an address-setup register, whose top two bits hold a setup code, and a timing register. The timing register packs the active count in its upper nibble and the recovery count in its lower nibble. Drives 0 and 1 each own a set. Drives 2 and 3, on the secondary channel, share one set. A chip-revision input lengthens the recovery phase on later revisions. The host computes the counts and writes them through the configuration port before it issues accesses.

Top module: `ide_strobe_timer`

## Requirements
- R1: Bits 7:6 of an address-setup register give the setup phase length: code 00 is 4 clocks, 01 is 2 clocks, 10 is 3 clocks and 11 is 5 clocks.
- R2: A configuration write with `cfg_setup_only` high to an address-setup register changes only bits 7:6 and leaves bits 5:0 as they were. With `cfg_setup_only` low, the whole byte is written.
- R3: A timing register holds the active count in bits 7:4 and the recovery count in bits 3:0. A nibble of 0 means 16 clocks. Configuration addresses are: 0 setup/1 timing for drive 0, 2 setup/3 timing for drive 1, and 4 setup/5 timing for the secondary pair. Addresses 6 and 7 read as zero and ignore writes.
- R4: The active phase is never shorter than 2 clocks. An active nibble of 1 runs as 2.
- R5: When the effective active length is above 3 and the recovery nibble is 1, recovery runs for 2 clocks.
- R6: When `chip_rev` is greater than 1, recovery lasts one clock more than the value from R3 and R5.
- R7: Drives 0 and 1 use their own register sets. Drives 2 and 3 both use the secondary set.
- R8: After reset, every register reads 0x00, so every drive runs setup 4, active 16 and recovery 16 (plus the R6 clock). `busy`, `ack` and both strobes are low.
- R9: `busy` is high from the edge that accepts a request to the end of recovery. `ack` pulses for one cycle with `busy` low right after recovery. Requests made while `busy` is high are not accepted. Only the strobe matching `req_write` is ever asserted.
- R10: The drive's timing and direction are latched when the request is accepted. Configuration writes during an access do not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_rev | input | 2 | Chip revision; values above 1 add a recovery clock |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_setup_only | input | 1 | On setup-register writes, update bits 7:6 only |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| req | input | 1 | Access request, accepted when idle |
| req_drive | input | 2 | Drive index for the request |
| req_write | input | 1 | 1 for a write strobe, 0 for a read strobe |
| busy | output | 1 | Access in progress |
| ack | output | 1 | One-cycle completion pulse |
| rd_stb | output | 1 | Read strobe, high during the active phase |
| wr_stb | output | 1 | Write strobe, high during the active phase |

## Verification
Two things can happen in the same cycle. A configuration write can land while an access is in flight, even on the very register set that access is using. A new request can also be pending while the current access is still busy. The bench provokes the first by rewriting drive 0's timing register in the first setup cycle of a drive 0 access. It then checks that every phase length still matches the value latched at acceptance. It provokes the second by holding `req` high, with a different drive, for the whole access. The measured phase lengths must stay unchanged, and no second access may start until the host releases `req`.

// File: rtl/ide_strobe_timer.sv
module ide_strobe_timer #(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] chip_rev,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic       cfg_setup_only,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       req,
  input  logic [1:0] req_drive,
  input  logic       req_write,
  output logic       busy,
  output logic       ack,
  output logic       rd_stb,
  output logic       wr_stb
);
  localparam int NSETS = 3;

  typedef enum logic [1:0] {IDLE, SETUP, ACTIVE, RECOV} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] cnt, a_q, r_q;
  logic             wr_q;
  logic [7:0]       setup_q  [NSETS];
  logic [7:0]       timing_q [NSETS];

  wire [1:0] cfg_set = cfg_addr[2:1];
  wire       cfg_hit = (cfg_set != 2'd3);
  wire [1:0] sel     = req_drive[1] ? 2'd2 : {1'b0, req_drive[0]};
  wire [3:0] a_nib   = timing_q[sel][7:4];
  wire [3:0] r_nib   = timing_q[sel][3:0];

  logic [CNT_W-1:0] s_len, a_len, r_base, r_len;

  always_comb begin
    case (setup_q[sel][7:6])
      2'b00:   s_len = CNT_W'(4);
      2'b01:   s_len = CNT_W'(2);
      2'b10:   s_len = CNT_W'(3);
      default: s_len = CNT_W'(5);
    endcase
    if (a_nib == 4'd0)      a_len = CNT_W'(16);
    else if (a_nib == 4'd1) a_len = CNT_W'(2);
    else                    a_len = CNT_W'(a_nib);
    if (r_nib == 4'd0)                            r_base = CNT_W'(16);
    else if (r_nib == 4'd1 && a_len > CNT_W'(3))  r_base = CNT_W'(2);
    else                                          r_base = CNT_W'(r_nib);
    r_len = r_base + ((chip_rev > 2'd1) ? CNT_W'(1) : CNT_W'(0));
  end

  assign cfg_rdata = !cfg_hit ? 8'h00 : (cfg_addr[0] ? timing_q[cfg_set] : setup_q[cfg_set]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSETS; i++) begin
        setup_q[i]  <= 8'h00;
        timing_q[i] <= 8'h00;
      end
    end else if (cfg_we && cfg_hit) begin
      if (cfg_addr[0])         timing_q[cfg_set]     <= cfg_wdata;
      else if (cfg_setup_only) setup_q[cfg_set][7:6] <= cfg_wdata[7:6];
      else                     setup_q[cfg_set]      <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= IDLE;
      cnt   <= '0;
      a_q   <= '0;
      r_q   <= '0;
      wr_q  <= 1'b0;
      ack   <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (phase)
        IDLE: if (req) begin
          phase <= SETUP;
          cnt   <= s_len - CNT_W'(1);
          a_q   <= a_len;
          r_q   <= r_len;
          wr_q  <= req_write;
        end
        SETUP: if (cnt == '0) begin
          phase <= ACTIVE;
          cnt   <= a_q - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        ACTIVE: if (cnt == '0) begin
          phase <= RECOV;
          cnt   <= r_q - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        default: if (cnt == '0) begin
          phase <= IDLE;
          ack   <= 1'b1;
        end else cnt <= cnt - CNT_W'(1);
      endcase
    end
  end

  assign busy   = (phase != IDLE);
  assign rd_stb = (phase == ACTIVE) && !wr_q;
  assign wr_stb = (phase == ACTIVE) &&  wr_q;
endmodule

// File: rtl/ide_strobe_timer_chk.sv
module ide_strobe_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [2:0] cfg_addr,
  input logic       cfg_setup_only,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       busy,
  input logic       ack,
  input logic       rd_stb,
  input logic       wr_stb
);
  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(rd_stb && wr_stb)); // R9
  AST_STB_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb || wr_stb) |-> busy); // R9
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ack |-> (!busy && $past(busy))); // R9
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R9
  AST_RD_ACTIVE_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_stb) |=> rd_stb); // R4
  AST_WR_ACTIVE_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_stb) |=> wr_stb); // R4
  AST_SETUP_KEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_setup_only && !cfg_addr[0] && cfg_addr[2:1] != 2'd3)
    |=> (!$stable(cfg_addr) || (cfg_rdata[5:0] == $past(cfg_rdata[5:0]) &&
                                cfg_rdata[7:6] == $past(cfg_wdata[7:6])))); // R2
endmodule

bind ide_strobe_timer ide_strobe_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_setup_only(cfg_setup_only), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .busy(busy), .ack(ack), .rd_stb(rd_stb), .wr_stb(wr_stb)
);

// File: tb/ide_strobe_timer_bench.sv
module ide_strobe_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chip_rev = 2'd1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic       cfg_setup_only = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       req = 1'b0;
  logic [1:0] req_drive = 2'd0;
  logic       req_write = 1'b0;
  logic       busy, ack, rd_stb, wr_stb;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ide_strobe_timer u_ide_strobe_timer (.*);

  // {code[35:34], act[33:30], rec[29:26], rev[25:24], s[23:16], a[15:8], r[7:0]}
  localparam logic [35:0] VEC [9] = '{
    {2'b00, 4'd0,  4'd0, 2'd1, 8'd4, 8'd16, 8'd16},
    {2'b01, 4'd1,  4'd1, 2'd1, 8'd2, 8'd2,  8'd1 },
    {2'b10, 4'd4,  4'd1, 2'd1, 8'd3, 8'd4,  8'd2 },
    {2'b11, 4'd5,  4'd3, 2'd2, 8'd5, 8'd5,  8'd4 },
    {2'b01, 4'd3,  4'd1, 2'd1, 8'd2, 8'd3,  8'd1 },
    {2'b00, 4'd0,  4'd0, 2'd3, 8'd4, 8'd16, 8'd17},
    {2'b10, 4'd1,  4'd1, 2'd2, 8'd3, 8'd2,  8'd2 },
    {2'b11, 4'd15, 4'd1, 2'd2, 8'd5, 8'd15, 8'd3 },
    {2'b01, 4'd2,  4'd0, 2'd0, 8'd2, 8'd2,  8'd16}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d, input bit only);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_setup_only = only;
    @(negedge clk);
    cfg_we = 1'b0; cfg_setup_only = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic run(input logic [1:0] drv, input logic wr, input bit hold, input bit midw,
                     input int es, input int ea, input int er, input string tag);
    int s = 0, a = 0, r = 0, k = 0;
    bit stbok = 1'b1, ackok;
    @(negedge clk);
    req = 1'b1; req_drive = drv; req_write = wr;
    @(posedge clk);
    @(negedge clk);
    if (hold) req_drive = 2'd3 - drv; else req = 1'b0;
    while (busy && k < 100) begin
      if (midw && k == 0) begin cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 8'h11; end
      if (k == 1) cfg_we = 1'b0;
      if (rd_stb || wr_stb) begin
        a++;
        if (wr ? (!wr_stb || rd_stb) : (!rd_stb || wr_stb)) stbok = 1'b0;
      end else if (a == 0) s++;
      else r++;
      k++;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    ackok = ack && !busy;
    req = 1'b0;
    @(negedge clk);
    if (busy || ack) ackok = 1'b0;
    chk(s == es, {tag, " setup"}, s, es);
    chk(a == ea, {tag, " active"}, a, ea);
    chk(r == er, {tag, " recovery"}, r, er);
    chk(ackok, {tag, " R9 ack/idle"}, ackok, 1);
    chk(stbok, {tag, " R9 strobe dir"}, stbok, 1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    chk(!busy && !ack && !rd_stb && !wr_stb, "R8 outputs idle", busy, 0);
    for (int i = 0; i < 8; i++) begin
      cfg_read(3'(i), d);
      chk(d == 8'h00, "R8 register reset", d, 0);
    end
    run(2'd3, 1'b0, 0, 0, 4, 16, 16, "R8 drive3 default");
    run(2'd1, 1'b1, 0, 0, 4, 16, 16, "R8 drive1 default");

    // R1 R3 R4 R5 R6 table
    foreach (VEC[i]) begin
      chip_rev = VEC[i][25:24];
      cfg_write(3'd0, {VEC[i][35:34], 6'd0}, 0);
      cfg_write(3'd1, {VEC[i][33:30], VEC[i][29:26]}, 0);
      run(2'd0, i[0], 0, 0, int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]),
          "R1/R3/R4/R5/R6 vector");
    end
    chip_rev = 2'd1;

    // R2 setup-only write keeps bits 5:0
    cfg_write(3'd2, 8'h2A, 0);
    cfg_write(3'd2, 8'hD5, 1);
    cfg_read(3'd2, d);
    chk(d == 8'hEA, "R2 setup-only write", d, 8'hEA);
    cfg_write(3'd2, 8'h55, 0);
    cfg_read(3'd2, d);
    chk(d == 8'h55, "R2 full write", d, 8'h55);

    // R3 unused addresses ignore writes
    cfg_write(3'd7, 8'hFF, 0);
    cfg_read(3'd7, d);
    chk(d == 8'h00, "R3 unused address", d, 0);

    // R7 sharing: secondary set, drive0 and drive1 separate
    cfg_write(3'd0, 8'h40, 0);
    cfg_write(3'd1, 8'h33, 0);
    cfg_write(3'd2, 8'h80, 0);
    cfg_write(3'd3, 8'h56, 0);
    cfg_write(3'd4, 8'hC0, 0);
    cfg_write(3'd5, 8'h78, 0);
    run(2'd2, 1'b0, 0, 0, 5, 7, 8, "R7 drive2 shared");
    run(2'd3, 1'b1, 0, 0, 5, 7, 8, "R7 drive3 shared");
    run(2'd1, 1'b0, 0, 0, 3, 5, 6, "R7 drive1 own");
    run(2'd0, 1'b1, 0, 0, 2, 3, 3, "R7 drive0 own");

    // R10 config write mid-access does not alter the access
    run(2'd0, 1'b0, 0, 1, 2, 3, 3, "R10 mid-access write");
    run(2'd0, 1'b0, 0, 0, 2, 2, 1, "R10 new timing next access");

    // R9 request held during access is ignored until idle
    run(2'd1, 1'b1, 1, 0, 3, 5, 6, "R9 held request");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule